// File: doc/BRIEF.md
# Four-Channel Nibble I/O Port Bank

This block holds four 4-bit bidirectional channels that a small processor core addresses directly with a 2-bit channel number. An output operation copies a nibble from the accumulator or from the B register into the chosen channel's output register. A pattern operation takes one 8-bit constant word and loads its two nibbles into the two upper channels in the same cycle.

Each pin is open-drain with a pull-up. The level on a pin is therefore the bitwise AND of the channel register and the external drive. An input operation samples the selected channel's pin level and returns it to the accumulator or to B one cycle later. The register keeps driving the pin during an input, so software must leave a channel at all ones before it reads that channel. Otherwise the register bits mask what the outside world drives.

The reset is asynchronous and active low. Its release is synchronised inside the block.

Top module: `nio_bank`

## Requirements
- R1: After reset every channel register holds 4'hF. With `ext_drive` all ones, `pin_level` reads 16'hFFFF, and `acc_ld_en` and `b_ld_en` are both low.
- R2: When `wr_en` is high and `wr_src` is 0, `acc_in` is stored in the channel given by `wr_sel` at the next clock edge. The other channels keep their values.
- R3: When `wr_en` is high and `wr_src` is 1, `b_in` is stored in the channel given by `wr_sel` at the next clock edge. The other channels keep their values.
- R4: When `pat_en` is high, `pat_word[7:4]` goes into channel 3 and `pat_word[3:0]` goes into channel 2 at the next edge. Channels 0 and 1 are not touched.
- R5: A pattern load and a write aimed at channel 2 or 3 in the same cycle resolve in favour of the pattern. A write to channel 0 or 1 in the same cycle as a pattern load still takes effect.
- R6: `pin_level[4n+3:4n]` always equals channel n's register ANDed bitwise with `ext_drive[4n+3:4n]`.
- R7: When `rd_en` is high, the next cycle shows `ld_data` equal to the selected channel's `pin_level` nibble from the request cycle. In that same next cycle, exactly one strobe is high: `acc_ld_en` when `rd_dst` is 0, or `b_ld_en` when `rd_dst` is 1.
- R8: In a cycle after one without `rd_en`, both strobes are low. With neither `wr_en` nor `pat_en`, all registers hold their values.
- R9: A read and a write to the same channel in the same cycle return the level from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Output operation request |
| wr_sel | input | 2 | Channel written |
| wr_src | input | 1 | Data source: 0 accumulator, 1 B |
| acc_in | input | 4 | Accumulator value |
| b_in | input | 4 | B register value |
| pat_en | input | 1 | Pattern load request |
| pat_word | input | 8 | Pattern constant: upper nibble to channel 3, lower nibble to channel 2 |
| rd_en | input | 1 | Input operation request |
| rd_sel | input | 2 | Channel read |
| rd_dst | input | 1 | Destination: 0 accumulator, 1 B |
| ext_drive | input | 16 | External open-drain drive, 1 means released |
| pin_level | output | 16 | Resolved pin levels, 4 bits per channel |
| acc_ld_en | output | 1 | Load strobe to the accumulator |
| b_ld_en | output | 1 | Load strobe to B |
| ld_data | output | 4 | Value returned by a read |

## Verification
A write or a pattern load appears on `pin_level` right after the edge that samples it, so the bench checks one time step after that edge. `pin_level` follows `ext_drive` with no register in between, so a change of the external drive is checked a step after it is applied, without waiting for a clock. A read result lands in the cycle after the request; the bench samples it after that single edge and then checks that the strobes fall on the following edge. Read-while-write cases confirm that the returned value comes from the earlier level.

// File: rtl/nio_pkg.sv
package nio_pkg;
  localparam int NIB_W = 4;

  typedef enum logic {
    SRC_ACC = 1'b0,
    SRC_B   = 1'b1
  } nio_src_e;
endpackage

// File: rtl/nio_rst_sync.sv
module nio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/nio_chan_reg.sv
module nio_chan_reg #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_hit,
  input  logic [W-1:0] wr_data,
  input  logic         pat_hit,
  input  logic [W-1:0] pat_data,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_en;

  always_comb begin
    q_en  = pat_hit | wr_hit;
    q_nxt = pat_hit ? pat_data : wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RST_VAL;
    else if (q_en) q <= q_nxt;
  end
endmodule

// File: rtl/nio_rd_port.sv
module nio_rd_port
  import nio_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int W    = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_en,
  input  logic [SELW-1:0] rd_sel,
  input  nio_src_e        rd_dst,
  input  logic [NCH*W-1:0] pin_level,
  output logic            acc_ld_en,
  output logic            b_ld_en,
  output logic [W-1:0]    ld_data
);
  logic         acc_nxt, b_nxt, data_en;
  logic [W-1:0] data_nxt;

  always_comb begin
    acc_nxt  = rd_en && (rd_dst == SRC_ACC);
    b_nxt    = rd_en && (rd_dst == SRC_B);
    data_en  = rd_en;
    data_nxt = pin_level[rd_sel*W +: W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ld_en <= 1'b0;
      b_ld_en   <= 1'b0;
    end else begin
      acc_ld_en <= acc_nxt;
      b_ld_en   <= b_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ld_data <= '0;
    else if (data_en) ld_data <= data_nxt;
  end
endmodule

// File: rtl/nio_bank.sv
module nio_bank
  import nio_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int W      = NIB_W,
  parameter int PAT_LO = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_sel,
  input  logic                  wr_src,
  input  logic [W-1:0]          acc_in,
  input  logic [W-1:0]          b_in,
  input  logic                  pat_en,
  input  logic [(NCH-PAT_LO)*W-1:0] pat_word,
  input  logic                  rd_en,
  input  logic [1:0]            rd_sel,
  input  logic                  rd_dst,
  input  logic [NCH*W-1:0]      ext_drive,
  output logic [NCH*W-1:0]      pin_level,
  output logic                  acc_ld_en,
  output logic                  b_ld_en,
  output logic [W-1:0]          ld_data
);
  localparam int SELW = (NCH > 1) ? $clog2(NCH) : 1;

  logic                  rst_sync_n;
  logic [NCH-1:0][W-1:0] chan_q;
  logic [W-1:0]          wr_data;

  nio_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    wr_data = (nio_src_e'(wr_src) == SRC_B) ? b_in : acc_in;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    logic         wr_hit;
    logic         pat_hit;
    logic [W-1:0] pat_data;

    always_comb wr_hit = wr_en && (wr_sel[SELW-1:0] == SELW'(ch));

    if (ch >= PAT_LO) begin : g_pat
      always_comb begin
        pat_hit  = pat_en;
        pat_data = pat_word[(ch-PAT_LO)*W +: W];
      end
    end else begin : g_nopat
      always_comb begin
        pat_hit  = 1'b0;
        pat_data = '0;
      end
    end

    nio_chan_reg #(.W(W), .RST_VAL('1)) u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_hit  (wr_hit),
      .wr_data (wr_data),
      .pat_hit (pat_hit),
      .pat_data(pat_data),
      .q       (chan_q[ch])
    );

    always_comb pin_level[ch*W +: W] = chan_q[ch] & ext_drive[ch*W +: W];
  end

  nio_rd_port #(.NCH(NCH), .W(W), .SELW(SELW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel[SELW-1:0]),
    .rd_dst   (nio_src_e'(rd_dst)),
    .pin_level(pin_level),
    .acc_ld_en(acc_ld_en),
    .b_ld_en  (b_ld_en),
    .ld_data  (ld_data)
  );
endmodule

// File: rtl/nio_bank_chk.sv
module nio_bank_chk #(
  parameter int NCH    = 4,
  parameter int W      = 4,
  parameter int PAT_LO = 2
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  wr_en,
  input logic [1:0]            wr_sel,
  input logic                  wr_src,
  input logic [W-1:0]          acc_in,
  input logic [W-1:0]          b_in,
  input logic                  pat_en,
  input logic [(NCH-PAT_LO)*W-1:0] pat_word,
  input logic                  rd_en,
  input logic [1:0]            rd_sel,
  input logic                  rd_dst,
  input logic [NCH*W-1:0]      pin_level,
  input logic                  acc_ld_en,
  input logic                  b_ld_en,
  input logic [W-1:0]          ld_data,
  input logic [NCH-1:0][W-1:0] chan_q
);
  // R2 R3 R5
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !(pat_en && int'(wr_sel) >= PAT_LO))
      |=> chan_q[$past(wr_sel)] == ($past(wr_src) ? $past(b_in) : $past(acc_in)));

  // R4
  pat_lands_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pat_en |=> chan_q[NCH-1:PAT_LO] == $past(pat_word));

  // R7
  rd_data_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_en |=> ld_data == $past(pin_level[rd_sel*W +: W])
              && acc_ld_en == !$past(rd_dst) && b_ld_en == $past(rd_dst));

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> !acc_ld_en && !b_ld_en);

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && !pat_en) |=> $stable(chan_q));

  // R7
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({acc_ld_en, b_ld_en}));
endmodule

bind nio_bank nio_bank_chk #(.NCH(NCH), .W(W), .PAT_LO(PAT_LO)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_src(wr_src), .acc_in(acc_in), .b_in(b_in), .pat_en(pat_en),
  .pat_word(pat_word), .rd_en(rd_en), .rd_sel(rd_sel), .rd_dst(rd_dst),
  .pin_level(pin_level), .acc_ld_en(acc_ld_en), .b_ld_en(b_ld_en),
  .ld_data(ld_data), .chan_q(chan_q)
);

// File: tb/nio_bank_bench.sv
module nio_bank_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_src = 1'b0, pat_en = 1'b0, rd_en = 1'b0, rd_dst = 1'b0;
  logic [1:0]  wr_sel = '0, rd_sel = '0;
  logic [3:0]  acc_in = '0, b_in = '0;
  logic [7:0]  pat_word = '0;
  logic [15:0] ext_drive = '1;
  logic [15:0] pin_level;
  logic        acc_ld_en, b_ld_en;
  logic [3:0]  ld_data;

  logic [3:0]  m [4];
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  nio_bank u_nio_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_src(wr_src),
    .acc_in(acc_in), .b_in(b_in), .pat_en(pat_en), .pat_word(pat_word),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_dst(rd_dst), .ext_drive(ext_drive),
    .pin_level(pin_level), .acc_ld_en(acc_ld_en), .b_ld_en(b_ld_en),
    .ld_data(ld_data)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] model();
    return {m[3], m[2], m[1], m[0]};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int ch, bit src, logic [3:0] v);
    wr_en = 1'b1; wr_sel = 2'(ch); wr_src = src;
    if (src) begin b_in = v; acc_in = ~v; end
    else     begin acc_in = v; b_in = ~v; end
    tick();
    wr_en = 1'b0;
    m[ch] = v;
  endtask

  task automatic rd(int ch, bit dst);
    rd_en = 1'b1; rd_sel = 2'(ch); rd_dst = dst;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = 4'hF;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // R1 reset state
    chk("R1 pins", pin_level, 16'hFFFF);
    chk("R1 strobes", {14'd0, acc_ld_en, b_ld_en}, 16'd0);

    // R2 R3 write sweep, every channel, value and source
    for (int ch = 0; ch < 4; ch++)
      for (int v = 0; v < 16; v++)
        for (int s = 0; s < 2; s++) begin
          wr(ch, s[0], 4'(v));
          chk(s ? "R3 write b" : "R2 write acc", pin_level, model());
        end

    // R4 pattern sweep with channels 0/1 holding distinct values
    wr(0, 1'b0, 4'h5); wr(1, 1'b1, 4'hA);
    for (int w = 0; w < 256; w++) begin
      pat_en = 1'b1; pat_word = 8'(w);
      tick();
      pat_en = 1'b0;
      m[3] = pat_word[7:4]; m[2] = pat_word[3:0];
      chk("R4 pattern", pin_level, model());
    end

    // R5 pattern beats write to channel 2, write to channel 0 proceeds
    pat_en = 1'b1; pat_word = 8'h3C;
    wr_en = 1'b1; wr_sel = 2'd2; wr_src = 1'b0; acc_in = 4'h0;
    tick();
    pat_en = 1'b0; wr_en = 1'b0;
    m[3] = 4'h3; m[2] = 4'hC;
    chk("R5 pattern wins", pin_level, model());
    pat_en = 1'b1; pat_word = 8'h81;
    wr_en = 1'b1; wr_sel = 2'd0; wr_src = 1'b1; b_in = 4'h6;
    tick();
    pat_en = 1'b0; wr_en = 1'b0;
    m[3] = 4'h8; m[2] = 4'h1; m[0] = 4'h6;
    chk("R5 write ch0 with pattern", pin_level, model());

    // R8 hold with no operation
    tick(); tick();
    chk("R8 hold", pin_level, model());

    // R6 wired-AND with external drive
    wr(0, 1'b0, 4'h9); wr(1, 1'b0, 4'h5); wr(2, 1'b1, 4'hF); wr(3, 1'b1, 4'h3);
    for (int e = 0; e < 256; e++) begin
      ext_drive = 16'(e * 16'h0101) ^ 16'h5A3C;
      #1;
      chk("R6 wired and", pin_level, model() & ext_drive);
    end

    // R7 read sweep with registers released
    for (int ch = 0; ch < 4; ch++) wr(ch, 1'b0, 4'hF);
    for (int ch = 0; ch < 4; ch++)
      for (int d = 0; d < 2; d++)
        for (int e = 0; e < 16; e++) begin
          ext_drive = 16'h0000;
          ext_drive[ch*4 +: 4] = 4'(e);
          rd(ch, d[0]);
          chk("R7 data", {12'd0, ld_data}, 16'(e));
          chk("R7 strobe", {14'd0, acc_ld_en, b_ld_en}, d ? 16'd1 : 16'd2);
        end
    tick();
    chk("R8 idle strobes", {14'd0, acc_ld_en, b_ld_en}, 16'd0);

    // R7 register masks input when not all ones
    wr(0, 1'b0, 4'h6);
    ext_drive = 16'hFFFC;
    rd(0, 1'b1);
    chk("R7 masked read", {12'd0, ld_data}, 16'h4);

    // R9 read and write same channel same cycle
    ext_drive = 16'hFFFF;
    rd_en = 1'b1; rd_sel = 2'd1; rd_dst = 1'b0;
    wr_en = 1'b1; wr_sel = 2'd1; wr_src = 1'b0; acc_in = 4'h2;
    tick();
    rd_en = 1'b0; wr_en = 1'b0;
    m[1] = 4'h2;
    chk("R9 read old level", {12'd0, ld_data}, 16'hF);
    chk("R9 write lands", pin_level, model());

    done = 1'b1;
    summary();
  end
endmodule